// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor with Dual Overflow Detection

This block adds or subtracts two two's complement operands of a parameterised width. The default width is 8. It is built as a ripple chain of full-adder cells. A single mode input picks the operation. In subtract mode every bit of the second operand is inverted by an XOR stage, and the mode bit enters the chain as the carry into the least significant cell, so the chain computes A + ~B + 1.

Two flag groups are reported.

- **Unsigned carry:** the carry out of the top cell is presented unchanged. In subtract mode a value of 1 means no borrow occurred.
- **Signed overflow:** this flag is produced by two independent detectors.
  - One compares the sign bits of A, of the effective (possibly inverted) B, and of the result.
  - The other takes the XOR of the carries into and out of the most significant cell.

Both overflow flags are brought out so that a system can confirm they always match. The block is purely combinational.

Top module: `addsub_ovf`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (`opa` + `opb`) modulo 2^WIDTH.
- R2: With `sub_mode` = 1, `result` equals (`opa` − `opb`) modulo 2^WIDTH, formed as `opa` + ~`opb` + 1.
- R3: `carry_out` is the carry out of the most significant cell: in add mode it is bit WIDTH of `opa` + `opb`, and in subtract mode it is 1 exactly when `opa` ≥ `opb` taken as unsigned numbers.
- R4: `ovf_by_sign` is 1 only when the sign bits of `opa` and of the effective B (`opb` XOR `sub_mode`) are equal and the sign bit of `result` differs from them.
- R5: `ovf_by_carry` is the XOR of the carry into and the carry out of the most significant cell, and it is 1 exactly when the signed result falls outside −2^(WIDTH−1) … 2^(WIDTH−1)−1.
- R6: `ovf_by_sign` and `ovf_by_carry` are equal for every input combination.
- R7: When the sign bits of `opa` and of the effective B differ, both overflow flags are 0.
- R8: These corner cases give the stated outputs (result, carry, overflow):
  - 80h+80h gives 00h, 1, 1.
  - 7Fh+01h gives 80h, 0, 1.
  - 7Fh+80h gives FFh, 0, 0.
  - 7Fh+C0h gives 3Fh, 1, 0.
  - 80h−01h gives 7Fh, 1, 1.
  - 00h−80h gives 80h, 0, 1.
- R9: All outputs depend only on the present inputs, with no state.
- R10: The same behaviour holds at WIDTH = 4. For example, Fh+1h gives 0h with carry 1, and 8h+8h gives 0h with carry 1 and overflow 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Sum or difference modulo 2^WIDTH |
| carry_out | output | 1 | Raw carry out of the most significant cell |
| ovf_by_sign | output | 1 | Signed overflow from the sign-bit rule |
| ovf_by_carry | output | 1 | Signed overflow from the MSB carry pair |

## Verification
The bench builds two copies of the block. The first uses WIDTH = 8 and is driven with every operand pair in both modes. This reaches every carry pattern along the chain and every sign combination, in both add and subtract mode. The second uses WIDTH = 4, which shows that the carry-pair detector follows the parameter and does not stay fixed at bit 7. Expected values come from integer arithmetic on the signed and unsigned meanings of the operands, not from bit-level carry logic.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic carry;
        logic v_sign;
        logic v_carry;
    } flags_t;

    function automatic logic bit_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    function automatic logic bit_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (x & ci) | (y & ci);
    endfunction

    // Sum-of-products form of the sign overflow rule
    function automatic logic sign_overflow(input logic sa, input logic sb, input logic sr);
        return (sa & sb & ~sr) | (~sa & ~sb & sr);
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell
    import addsub_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = bit_sum(x, y, ci);
        co = bit_carry(x, y, ci);
    end
endmodule

// File: rtl/operand_cond.sv
module operand_cond
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  op_e              op,
    output logic [WIDTH-1:0] b_eff
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign b_eff[i] = b_in[i] ^ op;
    end

    always_comb begin
        if (!$isunknown({b_in, op})) begin
            p_cond_sub_r2: assert (op != OP_SUB || b_eff == ~b_in)
                else $error("p_cond_sub_r2: B not inverted in subtract");
            p_cond_add_r1: assert (op != OP_ADD || b_eff == b_in)
                else $error("p_cond_add_r1: B altered in add");
        end
    end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH:0]   carry
);
    localparam int EXT = WIDTH + 1;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        fa_cell u_fa (
            .x  (a[i]),
            .y  (b[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    logic [EXT-1:0] ref_total;
    always_comb begin
        ref_total = EXT'(a) + EXT'(b) + EXT'(cin);
        if (!$isunknown({a, b, cin})) begin
            p_chain_sum_r1: assert ({carry[WIDTH], sum} == ref_total)
                else $error("p_chain_sum_r1: ripple chain total mismatch");
        end
    end
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect
    import addsub_pkg::*;
(
    input  logic sign_a,
    input  logic sign_b,
    input  logic sign_r,
    input  logic c_into_msb,
    input  logic c_out_msb,
    output logic v_sign,
    output logic v_carry
);
    always_comb begin
        v_sign  = sign_overflow(sign_a, sign_b, sign_r);
        v_carry = c_into_msb ^ c_out_msb;
    end

    always_comb begin
        if (!$isunknown({sign_a, sign_b, sign_r})) begin
            p_no_overflow_r7: assert (sign_a == sign_b || !v_sign)
                else $error("p_no_overflow_r7: overflow with differing signs");
        end
    end
endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             ovf_by_sign,
    output logic             ovf_by_carry
);
    localparam int MSB = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carries;
    flags_t           flags;

    assign op = op_e'(sub_mode);

    operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_in  (opb),
        .op    (op),
        .b_eff (b_eff)
    );

    ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a     (opa),
        .b     (b_eff),
        .cin   (op == OP_SUB),
        .sum   (result),
        .carry (carries)
    );

    ovf_detect u_ovf (
        .sign_a     (opa[MSB]),
        .sign_b     (b_eff[MSB]),
        .sign_r     (result[MSB]),
        .c_into_msb (carries[MSB]),
        .c_out_msb  (carries[WIDTH]),
        .v_sign     (flags.v_sign),
        .v_carry    (flags.v_carry)
    );

    assign flags.carry  = carries[WIDTH];
    assign carry_out    = flags.carry;
    assign ovf_by_sign  = flags.v_sign;
    assign ovf_by_carry = flags.v_carry;

    always_comb begin
        if (!$isunknown({opa, opb, sub_mode})) begin
            p_flags_agree_r6: assert (ovf_by_sign == ovf_by_carry)
                else $error("p_flags_agree_r6: overflow detectors disagree");
            p_no_borrow_r3: assert (!sub_mode || carry_out == (opa >= opb))
                else $error("p_no_borrow_r3: subtract carry not equal to no-borrow");
        end
    end
endmodule

// File: tb/addsub_ovf_test.sv
module addsub_ovf_test;

    typedef struct {
        logic [7:0] res8;
        logic       c8;
        logic       v8;
        logic [3:0] res4;
        logic       c4;
        logic       v4;
        logic       mode;
        logic       corner;
        logic       diff_sign8;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a8 = '0, b8 = '0;
    logic       mode = 1'b0;
    logic [7:0] r8;
    logic       c8, vs8, vc8;
    logic [3:0] r4;
    logic       c4, vs4, vc4;

    int  checks = 0;
    int  errors = 0;
    bit  driver_done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    addsub_ovf #(.WIDTH(8)) uut (
        .opa(a8), .opb(b8), .sub_mode(mode),
        .result(r8), .carry_out(c8), .ovf_by_sign(vs8), .ovf_by_carry(vc8)
    );

    addsub_ovf #(.WIDTH(4)) uut_narrow (
        .opa(a8[3:0]), .opb(b8[3:0]), .sub_mode(mode),
        .result(r4), .carry_out(c4), .ovf_by_sign(vs4), .ovf_by_carry(vc4)
    );

    // Model from integer arithmetic on unsigned and signed meanings
    function automatic void model(input int w, input int ua, input int ub, input bit sub,
                                  output int res, output bit cy, output bit ov);
        int mask = (1 << w) - 1;
        int half = 1 << (w - 1);
        int sa   = (ua >= half) ? ua - (1 << w) : ua;
        int sb   = (ub >= half) ? ub - (1 << w) : ub;
        int sr   = sub ? sa - sb : sa + sb;
        res = (sub ? ua - ub : ua + ub) & mask;
        cy  = sub ? (ua >= ub) : (((ua + ub) >> w) & 1) != 0;
        ov  = (sr > half - 1) || (sr < -half);
    endfunction

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic m, input bit corner);
        exp_t e;
        int r; bit cy; bit ov;
        @(posedge clk);
        a8 = a; b8 = b; mode = m;
        model(8, int'(a), int'(b), m, r, cy, ov);
        e.res8 = r[7:0]; e.c8 = cy; e.v8 = ov;
        model(4, int'(a[3:0]), int'(b[3:0]), m, r, cy, ov);
        e.res4 = r[3:0]; e.c4 = cy; e.v4 = ov;
        e.mode = m;
        e.corner = corner;
        e.diff_sign8 = a[7] != (b[7] ^ m);
        q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s a=%02h b=%02h m=%0d actual=%0h expected=%0h",
                     req, a8, b8, mode, act, exp);
        end
    endtask

    // Monitor: compares at the falling edge after inputs settle
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.corner) begin
                chk(r8 == e.res8, "R8 result", r8, e.res8);
                chk(c8 == e.c8,   "R8 carry",  c8, e.c8);
                chk(vs8 == e.v8,  "R8 overflow", vs8, e.v8);
            end
            chk(r8 == e.res8, e.mode ? "R2 result" : "R1 result", r8, e.res8);
            chk(c8 == e.c8, "R3 carry_out", c8, e.c8);
            chk(vs8 == e.v8, "R4 ovf_by_sign", vs8, e.v8);
            chk(vc8 == e.v8, "R5 ovf_by_carry", vc8, e.v8);
            chk(vs8 == vc8, "R6 flags agree", vs8, vc8);
            if (e.diff_sign8)
                chk(!vs8 && !vc8, "R7 differing signs", {vs8, vc8}, 0);
            chk(r4 == e.res4, "R10 narrow result", r4, e.res4);
            chk(c4 == e.c4, "R10 narrow carry", c4, e.c4);
            chk(vs4 == e.v4 && vc4 == e.v4, "R10 narrow overflow", {vs4, vc4}, {e.v4, e.v4});
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R9: all-zero inputs give all-zero outputs, with no history involved
        drive(8'h00, 8'h00, 1'b0, 1'b0);
        // R8 corner cases
        drive(8'h80, 8'h80, 1'b0, 1'b1);
        drive(8'h7F, 8'h01, 1'b0, 1'b1);
        drive(8'h7F, 8'h80, 1'b0, 1'b1);
        drive(8'h7F, 8'hC0, 1'b0, 1'b1);
        drive(8'h80, 8'h01, 1'b1, 1'b1);
        drive(8'h00, 8'h80, 1'b1, 1'b1);
        // R10 narrow corners (low nibbles): F+1, 8+8
        drive(8'h0F, 8'h01, 1'b0, 1'b0);
        drive(8'h08, 8'h08, 1'b0, 1'b0);
        // Exhaustive sweep, both modes; R9 repeated vectors follow unrelated ones
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 256; i++)
                for (int j = 0; j < 256; j++)
                    drive(8'(i), 8'(j), m[0], 1'b0);
        drive(8'h80, 8'h80, 1'b0, 1'b1);
        @(posedge clk);
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        driver_done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!driver_done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule